// File: doc/BRIEF.md
# Random Number Generator Register Controller

This block is the register front end of a hardware random number generator. A host reaches it through a single-cycle strobe bus. Through that bus the host can start a self-test or a seeding run, read completion and error flags, mask the interrupt, and pull 32-bit random words from a 16-entry output FIFO. The status register reports the FIFO level. Both operations take a fixed, parameterised number of cycles. An internal 32-bit LFSR stands in for the entropy source. Two hook inputs let a test force a self-test failure or a statistical failure at the moment an operation completes.

Once a seeding run succeeds, the FIFO fills with one word per cycle until it is full. It refills as the host drains it. Any recorded error halts filling. The interrupt-clear command and the error-clear command interact: the interrupt clear works only when the error register is empty, and the error clear works only when it is not. Software must therefore read the status and error registers before it clears anything.

Top module: `rng_regctl`

## Requirements
- R1: Register offsets are: command 0x04, control 0x08, status 0x0C, error 0x10, FIFO port 0x14. A read whose strobe is sampled at a clock edge returns its data on `bus_rdata` right after that edge. The command register always reads 0. Any unmapped offset reads 0.
- R2: A command write starts an operation. Bit 0 starts a self-test and bit 1 starts a seeding run. If both bits are set, the self-test is started. A start is ignored while an operation is running. The operation completes exactly OP_CYCLES edges after the accepting edge. Completion sets status bit 4 (self-test) or status bit 5 (seed).
- R3: Command bit 4 clears both done flags only when the error register is zero. While any error bit is set, bit 4 has no effect.
- R4: When the error register is non-zero, command bit 5 clears the error register and both done flags. When the error register is zero, bit 5 has no effect. If a completion falls on the same edge as a clear, the completion takes precedence.
- R5: Control bit 5 masks the done source and control bit 6 masks the error source. `irq` = (any done flag AND NOT bit 5) OR (any error bit AND NOT bit 6). It is registered and changes on the same edge as the flags and masks that feed it. Control reads return only bits 5 and 6.
- R6: If `inj_st_fail` is high at a self-test completion edge, error bit 0 is set. If `inj_stat_fail` is high at a seed completion edge, error bit 3 is set. Status bit 16 is the OR of all error bits.
- R7: A seed completion without a failure enables filling. From the next edge on, one word is pushed per edge while the FIFO holds fewer than 16 words. The words are successive states of a right-shift Galois LFSR. It starts at 0x00000001 and its next state is (s>>1) XOR (s[0] ? 0x80200003 : 0). The word pushed is the state before the shift.
- R8: Status bits 11:8 hold the FIFO word count, saturating at 15 when 16 words are held.
- R9: A read of the FIFO port with words present returns the oldest word and removes it.
- R10: A read of an empty FIFO returns 0 and leaves the level unchanged.
- R11: While any error bit is set, no word is pushed. Filling resumes once the error is cleared.
- R12: After reset, control reads 0x60, status and error read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid after the strobe edge |
| irq | output | 1 | Combined done/error interrupt |
| inj_st_fail | input | 1 | Test hook: fail the self-test at completion |
| inj_stat_fail | input | 1 | Test hook: flag a statistical failure at seed completion |

## Verification
Read data is due one edge after the strobe edge. It is sampled at the falling edge that follows and compared with the value the reference model captured at that rising edge. Flags, masks and `irq` all move on the edge that accepts a write or completes an operation. `irq` is compared at every falling edge, so any one-cycle skew shows up. Completion lands OP_CYCLES edges after the command. Filling starts one edge after seed completion and adds one word per edge. The model counts these edges itself, so level reads taken partway through a fill check that cadence.

// File: rtl/rng_regctl_pkg.sv
package rng_regctl_pkg;
  localparam int OFS_CMD  = 'h04;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_ERR  = 'h10;
  localparam int OFS_FIFO = 'h14;

  localparam int CMD_SELFTEST = 0;
  localparam int CMD_SEED     = 1;
  localparam int CMD_CLR_IRQ  = 4;
  localparam int CMD_CLR_ERR  = 5;

  localparam int CTL_MASK_DONE = 5;
  localparam int CTL_MASK_ERR  = 6;

  localparam int STS_ST_DONE = 4;
  localparam int STS_SD_DONE = 5;
  localparam int STS_LVL_LO  = 8;
  localparam int STS_ERR     = 16;

  localparam int ERRB_SELFTEST = 0;
  localparam int ERRB_STAT     = 3;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'd0,
    OP_SELFTEST = 2'd1,
    OP_SEEDING  = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int          W    = 32,
  parameter logic [31:0] TAPS = 32'h8020_0003,
  parameter logic [31:0] INIT = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= INIT[W-1:0];
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/rng_opseq.sv
module rng_opseq
  import rng_regctl_pkg::*;
#(
  parameter int OP_CYCLES = 64,
  localparam int CNT_W    = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_st,
  input  logic start_seed,
  output logic busy,
  output logic fin_st,
  output logic fin_seed
);
  op_kind_e   kind;
  logic [CNT_W-1:0] cnt;
  logic       last;

  assign busy     = (kind != OP_IDLE);
  assign last     = busy && (cnt == '0);
  assign fin_st   = last && (kind == OP_SELFTEST);
  assign fin_seed = last && (kind == OP_SEEDING);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind <= OP_IDLE;
      cnt  <= '0;
    end else if (busy) begin
      if (last) kind <= OP_IDLE;
      else      cnt  <= cnt - 1'b1;
    end else if (start_st || start_seed) begin
      kind <= start_st ? OP_SELFTEST : OP_SEEDING;
      cnt  <= CNT_W'(OP_CYCLES - 1);
    end
  end
endmodule

// File: rtl/rng_regctl.sv
module rng_regctl
  import rng_regctl_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 16,
  parameter int          LVL_W      = 4,
  parameter int          OP_CYCLES  = 64,
  parameter logic [31:0] LFSR_TAPS  = 32'h8020_0003,
  parameter logic [31:0] LFSR_INIT  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              inj_st_fail,
  input  logic              inj_stat_fail
);
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic wr_cmd, wr_ctl, rd_any, rd_fifo;
  logic st_done_q, sd_done_q, st_done_d, sd_done_d;
  logic err_st_q, err_stat_q, err_st_d, err_stat_d, err_any;
  logic mask_done_q, mask_err_q, mask_done_d, mask_err_d;
  logic seeded_q, seeded_d;
  logic clr_int_ok, clr_err_ok, clr_done;
  logic busy, fin_st, fin_seed;
  logic push, pop;
  logic [DATA_W-1:0] lfsr_word, fifo_word, stat_word, err_word, ctl_word;
  logic [DATA_W-1:0] rdata_reg_q;
  logic              fifo_sel_q;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [LVL_W-1:0]  level;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_cmd  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_ctl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign rd_any  = bus_sel && !bus_wr;
  assign rd_fifo = rd_any && (bus_addr == ADDR_W'(OFS_FIFO));

  assign err_any    = err_st_q || err_stat_q;
  assign clr_int_ok = wr_cmd && bus_wdata[CMD_CLR_IRQ] && !err_any;
  assign clr_err_ok = wr_cmd && bus_wdata[CMD_CLR_ERR] && err_any;
  assign clr_done   = clr_int_ok || clr_err_ok;

  rng_opseq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_st  (wr_cmd && bus_wdata[CMD_SELFTEST]),
    .start_seed(wr_cmd && bus_wdata[CMD_SEED] && !bus_wdata[CMD_SELFTEST]),
    .busy      (busy),
    .fin_st    (fin_st),
    .fin_seed  (fin_seed)
  );

  always_comb begin
    st_done_d   = fin_st   ? 1'b1 : (clr_done ? 1'b0 : st_done_q);
    sd_done_d   = fin_seed ? 1'b1 : (clr_done ? 1'b0 : sd_done_q);
    err_st_d    = (fin_st && inj_st_fail)     || (err_st_q   && !clr_err_ok);
    err_stat_d  = (fin_seed && inj_stat_fail) || (err_stat_q && !clr_err_ok);
    seeded_d    = seeded_q || (fin_seed && !inj_stat_fail);
    mask_done_d = wr_ctl ? bus_wdata[CTL_MASK_DONE] : mask_done_q;
    mask_err_d  = wr_ctl ? bus_wdata[CTL_MASK_ERR]  : mask_err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_done_q   <= 1'b0;
      sd_done_q   <= 1'b0;
      err_st_q    <= 1'b0;
      err_stat_q  <= 1'b0;
      seeded_q    <= 1'b0;
      mask_done_q <= 1'b1;
      mask_err_q  <= 1'b1;
      irq         <= 1'b0;
    end else begin
      st_done_q   <= st_done_d;
      sd_done_q   <= sd_done_d;
      err_st_q    <= err_st_d;
      err_stat_q  <= err_stat_d;
      seeded_q    <= seeded_d;
      mask_done_q <= mask_done_d;
      mask_err_q  <= mask_err_d;
      irq         <= ((st_done_d || sd_done_d) && !mask_done_d) ||
                     ((err_st_d || err_stat_d) && !mask_err_d);
    end
  end

  assign push = seeded_q && !err_any && (fifo_cnt < CNT_W'(FIFO_DEPTH));
  assign pop  = rd_fifo && (fifo_cnt != '0);

  rng_lfsr #(.W(DATA_W), .TAPS(LFSR_TAPS), .INIT(LFSR_INIT)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .adv  (push),
    .state(lfsr_word)
  );

  rng_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .wdata(lfsr_word),
    .pop  (pop),
    .rdata(fifo_word),
    .count(fifo_cnt)
  );

  generate
    if (CNT_W > LVL_W) begin : g_sat
      assign level = (fifo_cnt > CNT_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : fifo_cnt[LVL_W-1:0];
    end else begin : g_nosat
      assign level = LVL_W'(fifo_cnt);
    end
  endgenerate

  always_comb begin
    stat_word                        = '0;
    stat_word[STS_ST_DONE]           = st_done_q;
    stat_word[STS_SD_DONE]           = sd_done_q;
    stat_word[STS_LVL_LO +: LVL_W]   = level;
    stat_word[STS_ERR]               = err_any;
    err_word                         = '0;
    err_word[ERRB_SELFTEST]          = err_st_q;
    err_word[ERRB_STAT]              = err_stat_q;
    ctl_word                         = '0;
    ctl_word[CTL_MASK_DONE]          = mask_done_q;
    ctl_word[CTL_MASK_ERR]           = mask_err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_reg_q <= '0;
      fifo_sel_q  <= 1'b0;
    end else if (rd_any) begin
      fifo_sel_q <= pop;
      if (bus_addr == ADDR_W'(OFS_CTRL))      rdata_reg_q <= ctl_word;
      else if (bus_addr == ADDR_W'(OFS_STAT)) rdata_reg_q <= stat_word;
      else if (bus_addr == ADDR_W'(OFS_ERR))  rdata_reg_q <= err_word;
      else                                    rdata_reg_q <= '0;
    end
  end

  assign bus_rdata = fifo_sel_q ? fifo_word : rdata_reg_q;
endmodule

// File: rtl/rng_regctl_chk.sv
module rng_regctl_chk
  import rng_regctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              mask_done_q,
  input logic              mask_err_q,
  input logic [CW-1:0]     fifo_cnt,
  input logic              err_any
);
  logic unused_chk;
  assign unused_chk = ^bus_wdata;

  logic cmd_wr, fifo_rd;
  assign cmd_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign fifo_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_FIFO));

  p_fifo_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_irq_suppressed_r5: assert property (@(posedge clk) disable iff (rst)
    (mask_done_q && mask_err_q) |-> !irq);

  p_no_fill_on_err_r11: assert property (@(posedge clk) disable iff (rst)
    err_any |=> (fifo_cnt <= $past(fifo_cnt)));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && fifo_cnt == '0 && err_any) |=> (fifo_cnt == '0));

  p_clr_int_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[CMD_CLR_IRQ] && !bus_wdata[CMD_CLR_ERR] && err_any) |=> err_any);
endmodule

bind rng_regctl rng_regctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .mask_done_q(mask_done_q),
  .mask_err_q (mask_err_q),
  .fifo_cnt   (fifo_cnt),
  .err_any    (err_any)
);

// File: tb/tb_rng_regctl.sv
module tb_rng_regctl;
  localparam int OPC   = 64;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr  = 1'b0;
  logic [7:0]  addr  = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        inj_st   = 1'b0;
  logic        inj_stat = 1'b0;

  always #2 clk = ~clk;

  rng_regctl #(.OP_CYCLES(OPC), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
    .inj_st_fail(inj_st), .inj_stat_fail(inj_stat)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference model
  bit          m_st, m_sd, m_es, m_eq, m_seeded, m_md, m_me, m_busy, m_kst, m_irq;
  bit          eany, pushok, fst, fsd;
  int          m_cnt, sz, lvl;
  logic [31:0] m_lfsr, m_exp;
  logic [31:0] m_q[$];

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_sd = 0; m_es = 0; m_eq = 0; m_seeded = 0;
      m_md = 1; m_me = 1; m_busy = 0; m_kst = 0; m_irq = 0;
      m_cnt = 0; m_lfsr = 32'h1; m_exp = 0; m_q.delete();
    end else begin
      eany   = m_es | m_eq;
      sz     = m_q.size();
      pushok = m_seeded && !eany && sz < DEPTH;
      lvl    = (sz > 15) ? 15 : sz;
      if (sel && !wr) begin
        case (addr)
          8'h08: m_exp = {25'd0, m_me, m_md, 5'd0};
          8'h0C: m_exp = {15'd0, eany, 4'd0, lvl[3:0], 2'd0, m_sd, m_st, 4'd0};
          8'h10: m_exp = {28'd0, m_eq, 2'd0, m_es};
          8'h14: m_exp = (sz > 0) ? m_q.pop_front() : 32'h0;
          default: m_exp = 32'h0;
        endcase
      end
      if (pushok) begin
        m_q.push_back(m_lfsr);
        m_lfsr = lfsr_next(m_lfsr);
      end
      fst = m_busy && m_cnt == 0 && m_kst;
      fsd = m_busy && m_cnt == 0 && !m_kst;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else m_cnt--;
      end else if (sel && wr && addr == 8'h04 && (wdata[0] || wdata[1])) begin
        m_busy = 1; m_cnt = OPC - 1; m_kst = wdata[0];
      end
      if (sel && wr && addr == 8'h04) begin
        if (wdata[4] && !eany) begin m_st = 0; m_sd = 0; end
        if (wdata[5] && eany) begin m_st = 0; m_sd = 0; m_es = 0; m_eq = 0; end
      end
      if (sel && wr && addr == 8'h08) begin m_md = wdata[5]; m_me = wdata[6]; end
      if (fst) begin m_st = 1; if (inj_st) m_es = 1; end
      if (fsd) begin m_sd = 1; if (inj_stat) m_eq = 1; else m_seeded = 1; end
      m_irq = ((m_st || m_sd) && !m_md) || ((m_es || m_eq) && !m_me);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R5: interrupt compared on every cycle against the model
  always @(negedge clk) begin
    if (!rst && !finished) chk("R5 irq", {31'd0, irq}, {31'd0, m_irq});
  end

  task automatic wrt(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0;
    chk(tag, rdata, m_exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    chk("R12 irq after reset", {31'd0, irq}, 32'd0);
    rd(8'h08, "R12 control reset");
    rd(8'h0C, "R12 status reset");
    rd(8'h10, "R12 error reset");
    rd(8'h04, "R1 command reads zero");
    rd(8'h00, "R1 unmapped offset");
    rd(8'h18, "R1 unmapped offset high");
    rd(8'h14, "R10 empty fifo read");

    // R2: self-test, then a seed start while busy is ignored
    wrt(8'h08, 32'h0);
    wrt(8'h04, 32'h1);
    idle(10);
    wrt(8'h04, 32'h2);
    idle(70);
    rd(8'h0C, "R2 self-test done, seed ignored");
    wrt(8'h04, 32'h10);
    rd(8'h0C, "R3 clear interrupt without error");

    // R6 statistical failure, R3 blocked clear, R5 masks, R4 error clear
    inj_stat = 1;
    wrt(8'h04, 32'h2);
    idle(70);
    inj_stat = 0;
    rd(8'h10, "R6 statistical error bit");
    rd(8'h0C, "R6 status error bit");
    wrt(8'h04, 32'h10);
    rd(8'h10, "R3 clear interrupt blocked by error");
    rd(8'h0C, "R3 done kept while error");
    wrt(8'h08, 32'h40);
    idle(2);
    wrt(8'h08, 32'h60);
    rd(8'h08, "R5 control readback");
    wrt(8'h08, 32'h0);
    wrt(8'h04, 32'h20);
    rd(8'h10, "R4 error cleared");
    rd(8'h0C, "R4 done cleared with error");
    wrt(8'h04, 32'h20);
    rd(8'h0C, "R4 clear error no effect");

    // R2 priority: both start bits pick self-test
    wrt(8'h08, 32'h20);
    wrt(8'h04, 32'h3);
    idle(70);
    rd(8'h0C, "R2 both bits start self-test");
    wrt(8'h04, 32'h10);

    // R7/R8 successful seed and fill
    wrt(8'h04, 32'h2);
    idle(62);
    for (int i = 0; i < 6; i++) rd(8'h0C, "R8 level during fill");
    idle(20);
    rd(8'h0C, "R8 level saturates at 15");
    for (int i = 0; i < 20; i++) rd(8'h14, "R9 R7 fifo word order");
    rd(8'h0C, "R8 level after reads");

    // R11: an error halts filling; R10: empty reads
    inj_st = 1;
    wrt(8'h04, 32'h1);
    idle(70);
    inj_st = 0;
    rd(8'h10, "R6 self-test error bit");
    for (int i = 0; i < 17; i++) rd(8'h14, "R11 R10 drain under error");
    rd(8'h0C, "R10 level unchanged by empty read");
    idle(5);
    rd(8'h0C, "R11 no fill while error");
    wrt(8'h04, 32'h20);
    idle(20);
    rd(8'h0C, "R11 fill resumes after clear");
    for (int i = 0; i < 3; i++) rd(8'h14, "R7 words after resume");

    idle(2);
    finished = 1;
    summary();
    $finish;
  end
endmodule